// File: doc/BRIEF.md
# Bit-Serial SIMD Neighbourhood Processor Array

A row of `Q` one-bit processing elements, one per pixel column of an image line. Every element executes the same instruction in the same cycle, taken from a broadcast opcode and operand fields. A shared bidirectional bus, `Q` bits wide, carries one bit-plane of one image line into the array or back out of it in a single cycle. Work follows a load, operate, store pattern. Lines are shifted into per-element neighbourhood registers, a one-bit result is computed into each element's result bit, and the result line is driven back onto the bus.

Each element owns `NREG` neighbourhood registers. Each register is a five-cell vertical shift chain holding, for its column, the line two above, one above, the current line, one below and two below. Direct wires to the elements at distances one and two on each side supply horizontal neighbours. Together these form a reduced 5x5 window of 13 pixels: the vertical and horizontal cross plus the four nearest diagonals. No two-dimensional pixel buffer is needed. Two kinds of operation exist:
- **Logical operation:** combines the current-line bits of two registers of the same pixel through a 4-entry truth table.
- **Morphological operation:** compares the masked window of one register against a pattern.

Top module: `pe_array_top`

## Requirements
- R1: After reset every chain cell and every result bit is 0, so a STORE issued straight after reset drives all zeros.
- R2: LOAD (opcode 1) with register index `sel_a_i` moves each chain cell of that register one step up: cell k takes cell k+1. The bus bit enters cell 4. Cell 0 is two lines above, cell 2 is the current line and cell 4 is two lines below. All other registers keep their contents.
- R3: LOGIC (opcode 2) sets each result bit to `lut_i[{a,b}]`, where a is the current-line cell of register `sel_a_i` and b is the current-line cell of register `sel_b_i`.
- R4: MORPH (opcode 3) sets each result bit to 1 exactly when every window bit selected by `mask_i` equals the same bit of `pat_i`. It uses register `sel_a_i`. Window bit order is 0 C, 1 N, 2 NN, 3 S, 4 SS, 5 E, 6 EE, 7 W, 8 WW, 9 NE, 10 NW, 11 SE, 12 SW. E is the element at index i+1, and N is the line one above.
- R5: A neighbour position beyond either end of the array reads as 0.
- R6: When `inv_i` is 1 during MORPH, the result bit is the complement of the match in R4.
- R7: NOP (opcode 0), LOAD and STORE leave the result bits unchanged.
- R8: STORE (opcode 4) drives the result bits onto `line_io` in the same cycle. The array drives the bus at no other time.
- R9: A MORPH with an all-zero mask yields 1 in every element, or 0 with `inv_i` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Broadcast opcode: 0 NOP, 1 LOAD, 2 LOGIC, 3 MORPH, 4 STORE |
| sel_a_i | input | $clog2(NREG) | First register index (LOAD, MORPH, LOGIC operand a) |
| sel_b_i | input | $clog2(NREG) | Second register index (LOGIC operand b) |
| lut_i | input | 4 | Truth table for LOGIC |
| mask_i | input | 13 | Window bit mask for MORPH |
| pat_i | input | 13 | Window pattern for MORPH |
| inv_i | input | 1 | Complement the MORPH result |
| line_io | inout | Q | Bidirectional line bus |

## Verification
The bench shifts random lines into random registers and keeps a plain two-dimensional picture of every register in the bench. It then runs morphological matches with random masks, patterns and invert settings, and compares each stored line against the window taken from that picture.
- **Edge columns:** directed runs on all-ones images with single horizontal-neighbour masks probe the ends of the array. A design that wrapped around, or read a floating neighbour, would set or clear the outermost one or two elements wrongly.
- **Wrong chain register:** reading back an unselected register after every load catches a shift that lands in the wrong chain.
- **Truth-table index order:** random LOGIC operations expose a truth table indexed with its two operands swapped.
- **Result holding:** NOP, LOAD and STORE cycles between operations would reveal a result register that fails to hold.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int unsigned WIN_W   = 13;
  localparam int unsigned CHAIN_D = 5;
  localparam int unsigned MID     = 2;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_LOGIC = 3'd2,
    OP_MORPH = 3'd3,
    OP_STORE = 3'd4
  } pe_op_e;
endpackage

// File: rtl/pe_morph_reg.sv
module pe_morph_reg #(
  parameter int unsigned DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [DEPTH-1:0] cells_o
);
  logic [DEPTH-1:0] cells_q, cells_d;

  always_comb begin
    cells_d = {din, cells_q[DEPTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cells_q <= '0;
    else if (shift_en) cells_q <= cells_d;
  end

  assign cells_o = cells_q;
endmodule

// File: rtl/pe_cell.sv
module pe_cell
  import pe_pkg::*;
#(
  parameter int unsigned NREG = 16,
  localparam int unsigned SW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pe_op_e             op,
  input  logic [SW-1:0]      sel_a,
  input  logic [SW-1:0]      sel_b,
  input  logic [3:0]         lut,
  input  logic [WIN_W-1:0]   mask,
  input  logic [WIN_W-1:0]   pat,
  input  logic               inv,
  input  logic               bus_bit,
  input  logic [CHAIN_D-1:0] col_e,
  input  logic [CHAIN_D-1:0] col_ee,
  input  logic [CHAIN_D-1:0] col_w,
  input  logic [CHAIN_D-1:0] col_ww,
  output logic [CHAIN_D-1:0] col_o,
  output logic               acc_o
);
  logic [CHAIN_D-1:0] chain [NREG];
  logic [WIN_W-1:0]   win;
  logic               acc_q, acc_d, acc_en;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    pe_morph_reg #(.DEPTH(CHAIN_D)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en ((op == OP_LOAD) && (sel_a == SW'(g))),
      .din      (bus_bit),
      .cells_o  (chain[g])
    );
  end

  assign col_o = chain[sel_a];

  always_comb begin
    win[0]  = col_o[MID];
    win[1]  = col_o[MID-1];
    win[2]  = col_o[MID-2];
    win[3]  = col_o[MID+1];
    win[4]  = col_o[MID+2];
    win[5]  = col_e[MID];
    win[6]  = col_ee[MID];
    win[7]  = col_w[MID];
    win[8]  = col_ww[MID];
    win[9]  = col_e[MID-1];
    win[10] = col_w[MID-1];
    win[11] = col_e[MID+1];
    win[12] = col_w[MID+1];
  end

  always_comb begin
    acc_en = 1'b0;
    acc_d  = acc_q;
    case (op)
      OP_LOGIC: begin
        acc_en = 1'b1;
        acc_d  = lut[{chain[sel_a][MID], chain[sel_b][MID]}];
      end
      OP_MORPH: begin
        acc_en = 1'b1;
        acc_d  = (((win ^ pat) & mask) == '0) ^ inv;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/pe_array_top.sv
module pe_array_top
  import pe_pkg::*;
#(
  parameter int unsigned Q    = 16,
  parameter int unsigned NREG = 16,
  localparam int unsigned SW  = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          op_i,
  input  logic [SW-1:0]       sel_a_i,
  input  logic [SW-1:0]       sel_b_i,
  input  logic [3:0]          lut_i,
  input  logic [WIN_W-1:0]    mask_i,
  input  logic [WIN_W-1:0]    pat_i,
  input  logic                inv_i,
  inout  wire  [Q-1:0]        line_io
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  pe_op_e             op;
  logic [CHAIN_D-1:0] col    [Q];
  logic [CHAIN_D-1:0] e_col  [Q];
  logic [CHAIN_D-1:0] ee_col [Q];
  logic [CHAIN_D-1:0] w_col  [Q];
  logic [CHAIN_D-1:0] ww_col [Q];
  logic [Q-1:0]       acc_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign op = pe_op_e'(op_i);

  for (genvar i = 0; i < Q; i++) begin : g_pe
    if (i + 1 < Q) begin : g_e
      assign e_col[i] = col[i+1];
    end else begin : g_e0
      assign e_col[i] = '0;
    end
    if (i + 2 < Q) begin : g_ee
      assign ee_col[i] = col[i+2];
    end else begin : g_ee0
      assign ee_col[i] = '0;
    end
    if (i >= 1) begin : g_w
      assign w_col[i] = col[i-1];
    end else begin : g_w0
      assign w_col[i] = '0;
    end
    if (i >= 2) begin : g_ww
      assign ww_col[i] = col[i-2];
    end else begin : g_ww0
      assign ww_col[i] = '0;
    end

    pe_cell #(.NREG(NREG)) u_cell (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .op      (op),
      .sel_a   (sel_a_i),
      .sel_b   (sel_b_i),
      .lut     (lut_i),
      .mask    (mask_i),
      .pat     (pat_i),
      .inv     (inv_i),
      .bus_bit (line_io[i]),
      .col_e   (e_col[i]),
      .col_ee  (ee_col[i]),
      .col_w   (w_col[i]),
      .col_ww  (ww_col[i]),
      .col_o   (col[i]),
      .acc_o   (acc_vec[i])
    );
  end

  assign line_io = (op == OP_STORE) ? acc_vec : {Q{1'bz}};
endmodule

// File: rtl/pe_array_chk.sv
module pe_array_chk #(
  parameter int unsigned Q = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op_i,
  input logic [3:0]   lut_i,
  input logic [12:0]  mask_i,
  input logic         inv_i,
  input logic [Q-1:0] line_io,
  input logic [Q-1:0] acc_vec
);
  // R7: result bits hold through NOP, LOAD and STORE
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 || op_i == 3'd1 || op_i == 3'd4) |=> $stable(acc_vec));

  // R9: empty mask gives all ones, or all zeros when inverted
  a_r9_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 && mask_i == 13'd0) |=> (acc_vec == {Q{~$past(inv_i)}}));

  // R3: constant truth tables force a constant result line
  a_r3_lut_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2 && lut_i == 4'hF) |=> (acc_vec == {Q{1'b1}}));

  a_r3_lut_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2 && lut_i == 4'h0) |=> (acc_vec == {Q{1'b0}}));

  // R8: the bus carries the result line during STORE
  a_r8_store_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4) |-> (line_io == acc_vec));
endmodule

bind pe_array_top pe_array_chk #(.Q(Q)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .op_i    (op_i),
  .lut_i   (lut_i),
  .mask_i  (mask_i),
  .inv_i   (inv_i),
  .line_io (line_io),
  .acc_vec (acc_vec)
);

// File: tb/pe_array_top_bench.sv
`timescale 1ns/1ps
module pe_array_top_bench;
  localparam int Q    = 16;
  localparam int NREG = 16;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op;
  logic [3:0]  sel_a, sel_b;
  logic [3:0]  lut;
  logic [12:0] mask, pat;
  logic        inv;
  logic [Q-1:0] drv;
  logic         drv_en;
  wire  [Q-1:0] bus;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [Q-1:0] img [NREG][5];

  assign bus = drv_en ? drv : {Q{1'bz}};

  pe_array_top #(.Q(Q), .NREG(NREG)) u_pe_array_top (
    .clk(clk), .rst_n(rst_n), .op_i(op), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .lut_i(lut), .mask_i(mask), .pat_i(pat), .inv_i(inv), .line_io(bus)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic pix(int r, int dy, int dx, int i);
    int x = i + dx;
    if (x < 0 || x >= Q) return 1'b0;
    return img[r][2+dy][x];
  endfunction

  function automatic logic [Q-1:0] exp_morph(int r, logic [12:0] m, logic [12:0] p, logic iv);
    logic [Q-1:0] res;
    for (int i = 0; i < Q; i++) begin
      logic [12:0] w;
      w = {pix(r,1,-1,i), pix(r,1,1,i), pix(r,-1,-1,i), pix(r,-1,1,i),
           pix(r,0,-2,i), pix(r,0,-1,i), pix(r,0,2,i), pix(r,0,1,i),
           pix(r,2,0,i), pix(r,1,0,i), pix(r,-2,0,i), pix(r,-1,0,i), pix(r,0,0,i)};
      res[i] = ((((w ^ p) & m) == 13'd0) ? 1'b1 : 1'b0) ^ iv;
    end
    return res;
  endfunction

  task automatic issue(logic [2:0] o, int a, int b, logic [3:0] l,
                       logic [12:0] m, logic [12:0] p, logic iv, logic [Q-1:0] line);
    @(negedge clk);
    op = o; sel_a = 4'(a); sel_b = 4'(b); lut = l; mask = m; pat = p; inv = iv;
    drv = line; drv_en = (o == 3'd1);
    @(posedge clk);
    #1;
    drv_en = 1'b0; op = 3'd0;
  endtask

  task automatic load_line(int r, logic [Q-1:0] line);
    issue(3'd1, r, 0, 4'h0, 13'd0, 13'd0, 1'b0, line);
    for (int k = 0; k < 4; k++) img[r][k] = img[r][k+1];
    img[r][4] = line;
  endtask

  task automatic store_check(logic [Q-1:0] exp, string tag);
    logic [Q-1:0] got;
    @(negedge clk);
    op = 3'd4; drv_en = 1'b0;
    #2;
    got = bus;
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: bus=%h expected=%h", tag, got, exp);
    end
    @(posedge clk);
    #1;
    op = 3'd0;
  endtask

  task automatic morph_check(int r, logic [12:0] m, logic [12:0] p, logic iv, string tag);
    issue(3'd3, r, 0, 4'h0, m, p, iv, '0);
    store_check(exp_morph(r, m, p, iv), tag);
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end

  initial begin
    op = 3'd0; sel_a = '0; sel_b = '0; lut = '0; mask = '0; pat = '0; inv = 1'b0;
    drv = '0; drv_en = 1'b0; rst_n = 1'b0;
    for (int r = 0; r < NREG; r++) for (int k = 0; k < 5; k++) img[r][k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset leaves result bits zero
    store_check('0, "R1 reset result");
    // R1/R4: all registers clear, center match against 1 gives zeros
    for (int r = 0; r < NREG; r++) morph_check(r, 13'h1, 13'h1, 1'b0, "R1 reset chain");

    // R9: empty mask, both invert settings
    morph_check(3, 13'd0, 13'h1FFF, 1'b0, "R9 empty mask");
    morph_check(3, 13'd0, 13'h0AAA, 1'b1, "R9 empty mask inverted");

    // R5: all-ones image, single horizontal neighbour probes at the edges
    for (int k = 0; k < 5; k++) load_line(0, {Q{1'b1}});
    morph_check(0, 13'h0020, 13'h0020, 1'b0, "R5 E edge");
    morph_check(0, 13'h0040, 13'h0040, 1'b0, "R5 EE edge");
    morph_check(0, 13'h0080, 13'h0080, 1'b0, "R5 W edge");
    morph_check(0, 13'h0100, 13'h0100, 1'b0, "R5 WW edge");
    morph_check(0, 13'h1E00, 13'h1E00, 1'b0, "R5 diagonal edges");

    // R2: staircase lines reveal cell order
    for (int k = 0; k < 5; k++) load_line(1, Q'(16'h0001 << k));
    for (int b = 0; b < 5; b++) begin
      logic [12:0] m;
      m = (b == 0) ? 13'h1 : (b == 1) ? 13'h2 : (b == 2) ? 13'h4 : (b == 3) ? 13'h8 : 13'h10;
      morph_check(1, m, m, 1'b0, "R2 cell order");
    end

    // R7: result holds through NOP, LOAD and STORE
    issue(3'd3, 1, 0, 4'h0, 13'h1, 13'h1, 1'b0, '0);
    issue(3'd0, 0, 0, 4'h0, 13'h0, 13'h0, 1'b1, '0);
    load_line(5, 16'hBEEF);
    store_check(16'h0004, "R7 hold after NOP and LOAD");
    store_check(16'h0004, "R7 hold after STORE");

    // R2/R3/R4/R6: random sweep against the picture model
    for (int t = 0; t < 400; t++) begin
      int r, o;
      logic [12:0] m, p;
      logic iv;
      r = $urandom_range(0, NREG - 1);
      load_line(r, Q'($urandom));
      o = (r + 1 + $urandom_range(0, NREG - 2)) % NREG;
      morph_check(o, 13'h1, 13'h1, 1'b0, "R2 other register unchanged");
      m = 13'($urandom); p = 13'($urandom); iv = 1'($urandom);
      if (t % 4 == 0) m = 13'($urandom) & 13'($urandom) & 13'($urandom);
      morph_check(r, m, p, iv, iv ? "R6 inverted morph" : "R4 morph match");
      begin
        int a, b;
        logic [3:0] l;
        logic [Q-1:0] e;
        a = $urandom_range(0, NREG - 1);
        b = $urandom_range(0, NREG - 1);
        l = 4'($urandom);
        for (int i = 0; i < Q; i++) e[i] = l[{img[a][2][i], img[b][2][i]}];
        issue(3'd2, a, b, l, 13'd0, 13'd0, 1'b0, '0);
        store_check(e, "R3 logic");
      end
    end

    // R8: store of a known line then of its opposite
    for (int k = 0; k < 5; k++) load_line(2, 16'h5A5A);
    morph_check(2, 13'h1, 13'h1, 1'b0, "R8 store line");
    morph_check(2, 13'h1, 13'h1, 1'b1, "R8 store complement");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end
endmodule